// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a signed-agnostic position count for a rotary or linear encoder. It takes two phase inputs, an index pulse, a home pulse, an external direction level and an external gate level. It turns them into a position value of parameter width, 32 bits by default. One of four count sources is selected at a time:
- full x4 decoding of the two phases;
- rising edges of phase A, with a direction input;
- rising edges of phase A, with the direction set by configuration alone;
- a free-running internal timer.

A power-of-two prescaler sits in front of the three non-quadrature sources.

In the two position-tracking sources, the index and home inputs can force the count to zero or load it from a preset, according to an initialization policy. In quadrature mode, index events are only accepted when the phases sit at a programmed level pair. The same policy field also selects a compare-and-clear rule, or wrap-around between a low and a high bound. Software programs everything through a flat register write port. A combinational read port returns any register, and the position is also driven out directly.

Top module: `qenc_poscnt`

## Requirements
- R1: After reset the position reads 0 and the control word reads 0, so the counter is disabled.
- R2: Register addresses are 0 control, 1 position, 2 preset, 3 compare, 4 low bound and 5 high bound; other read addresses return 0. Control bits are:
  - bit 0: enable
  - bits 3:1: policy
  - bits 5:4: index level pair {B,A}
  - bits 8:6: divider code
  - bit 9: polarity
  - bit 10: gate enable
  - bits 12:11: source

  With enable 0 every register is writable and readable and the position does not move. A position write always takes priority.
- R3: Source 00 counts one step for each single-phase change of A or B. The step is up when A leads B (sequence {B,A} 00,01,11,10) with polarity 0, and down otherwise. Polarity 1 inverts the direction. A cycle in which both phases change counts nothing.
- R4: Sources 01 and 10 count one prescaled step per rising edge of A. In source 01 the direction is down when polarity XOR direction input is 1. In source 10 the direction is down when polarity is 1.
- R5: Divider codes 0 to 7 divide by 1, 2, 4, 8, 16, 32, 64 and 256. In source 11 the position advances once per divided group of clock cycles, starting from the cycle after the control write, which also clears the divider.
- R6: With gate enable 1, steps happen only while the gate input is high. With gate enable 0 the gate input is ignored.
- R7: Policy 000 ignores the index. Policy 001 clears the position on each index rising edge. In source 00 an index edge counts only when {B,A} equals the programmed level pair.
- R8: Policy 010 loads the preset on the first index edge after a control write that selects 010, and on no later edge until the next such write.
- R9: Policy 011 loads the preset on the first index edge after a home rising edge. Policy 100 loads it on the second such edge. Index edges before any home edge, or after the load, leave the position alone until home rises again.
- R10: Policy 101: when the position equals the compare value, it becomes 0 on the next clock.
- R11: Policies 110 and 111 wrap between the bounds: an up step from the high bound gives the low bound, and a down step from the low bound gives the high bound. Policy 111 also clears the position on each index edge.
- R12: In sources 10 and 11 the policy field and the index and home inputs have no effect on the position.
- R13: The phase, index, home, direction and gate inputs pass through two synchronizing flops. A phase change applied before a clock edge shows on the position output after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A / external clock |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Index pulse |
| enc_home | input | 1 | Home pulse |
| ext_dir | input | 1 | External direction level (1 flips direction) |
| ext_gate | input | 1 | External count gate level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W | Register read data (combinational) |
| pos_o | output | W | Current position |

## Verification
The encoder is walked forwards and backwards around its whole gray cycle under both polarities, with a simultaneous double-phase change inserted. This separates direction decoding from invalid-transition rejection. Index pulses are applied at every {B,A} state for every programmed level pair, which checks that qualification accepts exactly one state out of four. The timer is run a fixed number of cycles for all eight divider codes, and the expected count is computed by integer division. External-clock runs cover all polarity and direction combinations, so an inverted XOR is caught. Home and index sequences, compare-clear and both wrap edges are checked against a step model of the position kept in the bench.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD     = 2'b00,
        SRC_EXT_DIR  = 2'b01,
        SRC_EXT_GATE = 2'b10,
        SRC_TIMER    = 2'b11
    } src_e;

    typedef enum logic [2:0] {
        INI_NONE     = 3'd0,
        INI_IDX_ZERO = 3'd1,
        INI_NEXT_IDX = 3'd2,
        INI_HOME_1ST = 3'd3,
        INI_HOME_2ND = 3'd4,
        INI_CMP_ZERO = 3'd5,
        INI_MODULO   = 3'd6,
        INI_MOD_IDX  = 3'd7
    } ini_e;

    // LSB first: en[0] ini[3:1] match[5:4] div[8:6] pol[9] gate_en[10] src[12:11]
    typedef struct packed {
        src_e       src;
        logic       gate_en;
        logic       pol;
        logic [2:0] div;
        logic [1:0] match;
        ini_e       ini;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_POS  = 3'd1;
    localparam logic [2:0] ADR_INIT = 3'd2;
    localparam logic [2:0] ADR_CMP  = 3'd3;
    localparam logic [2:0] ADR_LO   = 3'd4;
    localparam logic [2:0] ADR_HI   = 3'd5;

    // sync vector bit positions
    localparam int S_A    = 0;
    localparam int S_B    = 1;
    localparam int S_IDX  = 2;
    localparam int S_HOME = 3;
    localparam int S_DIR  = 4;
    localparam int S_GATE = 5;
    localparam int S_N    = 6;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg_d [STAGES];
    logic [N-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qenc_quad_dec.sv
module qenc_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic step,
    output logic up
);
    logic [1:0] prev_d, prev_q;
    logic [1:0] cur, diff;

    always_comb begin
        cur    = {b, a};
        diff   = cur ^ prev_q;
        prev_d = cur;
        step   = (diff == 2'b01) || (diff == 2'b10);
        // A changed: up when A now differs from B; B changed: up when equal
        up     = diff[0] ? (a ^ b) : ~(a ^ b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= prev_d;
    end

    assert_no_double_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && diff[0]) |-> $stable(b));
endmodule

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
    parameter int CW = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       evt,
    input  logic [2:0] code,
    output logic       tick
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;
    logic [3:0]    shamt;

    always_comb begin
        shamt = (code == 3'd7) ? 4'd8 : {1'b0, code};
        lim   = CW'(1) << shamt;
        tick  = evt && (cnt_q == lim - CW'(1));
        cnt_d = cnt_q;
        if (evt) cnt_d = tick ? '0 : cnt_q + CW'(1);
        if (clr) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_presc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);
endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
    import qenc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enc_a,
    input  logic         enc_b,
    input  logic         enc_idx,
    input  logic         enc_home,
    input  logic         ext_dir,
    input  logic         ext_gate,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pos_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        ctrl_t       ctrl;
        logic [W-1:0] pos;
        logic [W-1:0] pre;
        logic [W-1:0] cmp;
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic        arm;
        logic [1:0]  hst;
        logic        idx_p;
        logic        home_p;
        logic        a_p;
    } st_t;

    st_t st_d, st_q;

    logic [S_N-1:0] raw_in, syn;
    logic qd_step, qd_up;
    logic presc_evt, presc_tick, presc_clr;
    logic a_rise, idx_rise, home_rise, gate_ok, is_timer, idx_evt;
    logic step, down, mod_mode;
    logic [W-1:0] step_val, pos_n;
    ctrl_t wc;

    assign raw_in = {ext_gate, ext_dir, enc_home, enc_idx, enc_b, enc_a};

    qenc_sync #(.N(S_N), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    qenc_quad_dec dec_i (
        .clk(clk), .rst_n(rst_n), .a(syn[S_A]), .b(syn[S_B]),
        .step(qd_step), .up(qd_up)
    );

    qenc_prescale #(.CW(9)) presc_i (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .evt(presc_evt),
        .code(st_q.ctrl.div), .tick(presc_tick)
    );

    // edge detection and event qualification
    always_comb begin
        a_rise    = syn[S_A] & ~st_q.a_p;
        idx_rise  = syn[S_IDX] & ~st_q.idx_p;
        home_rise = syn[S_HOME] & ~st_q.home_p;
        gate_ok   = !st_q.ctrl.gate_en || syn[S_GATE];
        is_timer  = st_q.ctrl.src[1];
        presc_clr = wr_en && (wr_addr == ADR_CTRL);
        unique case (st_q.ctrl.src)
            SRC_QUAD:  presc_evt = 1'b0;
            SRC_TIMER: presc_evt = st_q.ctrl.en && gate_ok;
            default:   presc_evt = st_q.ctrl.en && gate_ok && a_rise;
        endcase
        idx_evt = st_q.ctrl.en && !is_timer && idx_rise &&
                  ((st_q.ctrl.src != SRC_QUAD) || ({syn[S_B], syn[S_A]} == st_q.ctrl.match));
    end

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.a_p    = syn[S_A];
        st_d.idx_p  = syn[S_IDX];
        st_d.home_p = syn[S_HOME];
        wc          = ctrl_t'(wr_data[CTRL_W-1:0]);

        unique case (st_q.ctrl.src)
            SRC_QUAD: begin
                step = st_q.ctrl.en && gate_ok && qd_step;
                down = ~qd_up ^ st_q.ctrl.pol;
            end
            SRC_EXT_DIR: begin
                step = presc_tick;
                down = st_q.ctrl.pol ^ syn[S_DIR];
            end
            default: begin
                step = presc_tick;
                down = st_q.ctrl.pol;
            end
        endcase

        mod_mode = !is_timer &&
                   ((st_q.ctrl.ini == INI_MODULO) || (st_q.ctrl.ini == INI_MOD_IDX));
        step_val = down ? st_q.pos - ONE : st_q.pos + ONE;
        if (mod_mode) begin
            if (!down && st_q.pos == st_q.hi)     step_val = st_q.lo;
            else if (down && st_q.pos == st_q.lo) step_val = st_q.hi;
        end

        pos_n = step ? step_val : st_q.pos;

        if (st_q.ctrl.en && !is_timer) begin
            unique case (st_q.ctrl.ini)
                INI_IDX_ZERO, INI_MOD_IDX: begin
                    if (idx_evt) pos_n = '0;
                end
                INI_NEXT_IDX: begin
                    if (idx_evt && st_q.arm) begin
                        pos_n    = st_q.pre;
                        st_d.arm = 1'b0;
                    end
                end
                INI_HOME_1ST: begin
                    if (home_rise) st_d.hst = 2'd1;
                    else if (idx_evt && st_q.hst == 2'd1) begin
                        pos_n    = st_q.pre;
                        st_d.hst = 2'd3;
                    end
                end
                INI_HOME_2ND: begin
                    if (home_rise) st_d.hst = 2'd1;
                    else if (idx_evt && st_q.hst == 2'd1) st_d.hst = 2'd2;
                    else if (idx_evt && st_q.hst == 2'd2) begin
                        pos_n    = st_q.pre;
                        st_d.hst = 2'd3;
                    end
                end
                INI_CMP_ZERO: begin
                    if (st_q.pos == st_q.cmp) pos_n = '0;
                end
                default: ;
            endcase
        end
        st_d.pos = pos_n;

        if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    st_d.ctrl = wc;
                    if (wc.ini == INI_NEXT_IDX) st_d.arm = 1'b1;
                end
                ADR_POS:  st_d.pos = wr_data;
                ADR_INIT: st_d.pre = wr_data;
                ADR_CMP:  st_d.cmp = wr_data;
                ADR_LO:   st_d.lo  = wr_data;
                ADR_HI:   st_d.hi  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADR_CTRL: rd_data = {{(W-CTRL_W){1'b0}}, st_q.ctrl};
            ADR_POS:  rd_data = st_q.pos;
            ADR_INIT: rd_data = st_q.pre;
            ADR_CMP:  rd_data = st_q.cmp;
            ADR_LO:   rd_data = st_q.lo;
            ADR_HI:   rd_data = st_q.hi;
            default:  rd_data = '0;
        endcase
    end

    assign pos_o = st_q.pos;

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !(wr_en && wr_addr == ADR_POS)) |=> (st_q.pos == $past(st_q.pos)));

    assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arm && st_q.ctrl.ini == INI_NEXT_IDX && idx_evt && !wr_en) |=> !st_q.arm);

    assert_cmp_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && !is_timer && st_q.ctrl.ini == INI_CMP_ZERO &&
         st_q.pos == st_q.cmp && !wr_en) |=> (st_q.pos == '0));

    assert_mod_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && !is_timer && st_q.ctrl.ini == INI_MODULO && !wr_en &&
         st_q.lo <= st_q.hi && st_q.pos >= st_q.lo && st_q.pos <= st_q.hi)
        |=> (st_q.pos >= st_q.lo && st_q.pos <= st_q.hi));

    assert_timer_no_index_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_timer && !step && !wr_en) |=> (st_q.pos == $past(st_q.pos)));
endmodule

// File: tb/qenc_poscnt_tb_top.sv
module qenc_poscnt_tb_top;
    localparam int  W          = 32;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pha = 0, phb = 0, idx = 0, home = 0, dir_in = 0, gate_in = 0;
    logic wr_en = 0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [W-1:0] rd_data, pos;

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] exp_pos = '0;
    logic [1:0]   ba = 2'b00;
    bit mdl_mod = 0, mdl_cmp = 0;
    logic [W-1:0] m_lo = '0, m_hi = '0, m_cv = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_poscnt #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a(pha), .enc_b(phb), .enc_idx(idx),
        .enc_home(home), .ext_dir(dir_in), .ext_gate(gate_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pos_o(pos)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [W-1:0] mk(bit en, int ini, int mt, int dv, bit pol, bit gen, int src);
        logic [12:0] c;
        c = {src[1:0], gen, pol, dv[2:0], mt[1:0], ini[2:0], en};
        return W'(c);
    endfunction

    function automatic void mstep(bit up);
        if (mdl_mod && up && exp_pos == m_hi)       exp_pos = m_lo;
        else if (mdl_mod && !up && exp_pos == m_lo) exp_pos = m_hi;
        else exp_pos = up ? exp_pos + 1 : exp_pos - 1;
        if (mdl_cmp && exp_pos == m_cv) exp_pos = '0;
    endfunction

    function automatic logic [1:0] nxt(logic [1:0] s, bit fwd);
        logic [1:0] f;
        case (s)
            2'b00: f = 2'b01;
            2'b01: f = 2'b11;
            2'b11: f = 2'b10;
            default: f = 2'b00;
        endcase
        if (fwd) return f;
        case (s)
            2'b01: return 2'b00;
            2'b11: return 2'b01;
            2'b10: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // one encoder move; counts == whether the design should step
    task automatic qmove(bit fwd, bit pol, bit counts);
        ba = nxt(ba, fwd);
        pha = ba[0]; phb = ba[1];
        settle();
        if (counts) mstep(fwd != pol);
    endtask

    task automatic pulse_idx();
        idx = 1; settle(); idx = 0; settle();
    endtask

    task automatic pulse_home();
        home = 1; settle(); home = 0; settle();
    endtask

    task automatic pulse_a();
        pha = 1; settle(); pha = 0; settle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pos after reset", pos, '0);
        rd_addr = 3'd0; #1;
        chk("R1 ctrl after reset", rd_data, '0);

        // R2 disabled: registers accessible, no counting
        wr(3'd1, 32'h55);
        wr(3'd2, 32'hA5A5_0F0F);
        rd_addr = 3'd2; #1; chk("R2 preset readback", rd_data, 32'hA5A5_0F0F);
        rd_addr = 3'd1; #1; chk("R2 pos readback", rd_data, 32'h55);
        rd_addr = 3'd7; #1; chk("R2 unused addr", rd_data, '0);
        exp_pos = 32'h55;
        for (int i = 0; i < 3; i++) begin
            qmove(1, 0, 0);
            chk("R2 no count while disabled", pos, exp_pos);
        end

        // R3 quadrature both polarities
        wr(3'd1, 32'd100); exp_pos = 32'd100;
        for (int p = 0; p < 2; p++) begin
            wr(3'd0, mk(1, 0, 0, 0, p[0], 0, 0));
            rd_addr = 3'd0; #1; chk("R2 ctrl readback", rd_data, mk(1, 0, 0, 0, p[0], 0, 0));
            for (int i = 0; i < 6; i++) begin
                qmove(1, p[0], 1); chk("R3 forward step", pos, exp_pos);
            end
            for (int i = 0; i < 9; i++) begin
                qmove(0, p[0], 1); chk("R3 backward step", pos, exp_pos);
            end
        end
        // R3 invalid double change
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0));
        ba = ~ba; pha = ba[0]; phb = ba[1]; settle();
        chk("R3 double change ignored", pos, exp_pos);
        qmove(1, 0, 1); chk("R3 step after invalid", pos, exp_pos);

        // R6 gate in quadrature mode
        wr(3'd0, mk(1, 0, 0, 0, 0, 1, 0));
        gate_in = 0;
        qmove(1, 0, 0); chk("R6 gate low blocks", pos, exp_pos);
        gate_in = 1; settle();
        qmove(1, 0, 1); chk("R6 gate high counts", pos, exp_pos);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0));
        gate_in = 0; settle();
        qmove(1, 0, 1); chk("R6 gate ignored when disabled", pos, exp_pos);

        // R13 latency: output moves after the third edge
        ba = nxt(ba, 1);
        @(negedge clk); pha = ba[0]; phb = ba[1];
        @(negedge clk); @(negedge clk);
        chk("R13 not yet after two edges", pos, exp_pos);
        @(negedge clk);
        mstep(1);
        chk("R13 moved after third edge", pos, exp_pos);
        settle();

        // bring encoder to 00 for external clock tests
        while (ba != 2'b00) qmove(1, 0, 1);

        // R4 external clock with direction input
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 2; d++) begin
                dir_in = d[0]; settle();
                wr(3'd0, mk(1, 0, 0, 0, p[0], 0, 1));
                for (int i = 0; i < 3; i++) begin
                    pulse_a(); mstep(!(p[0] ^ d[0]));
                    chk("R4 ext dir step", pos, exp_pos);
                end
            end
        end
        // R4 external clock, direction input ignored
        dir_in = 1; settle();
        for (int p = 0; p < 2; p++) begin
            wr(3'd0, mk(1, 0, 0, 0, p[0], 0, 2));
            for (int i = 0; i < 2; i++) begin
                pulse_a(); mstep(!p[0]);
                chk("R4 ext gate-mode step", pos, exp_pos);
            end
        end
        dir_in = 0;
        // R5 prescale in external clock mode (divide by 4)
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 1));
        wr(3'd1, '0); exp_pos = '0;
        wr(3'd0, mk(1, 0, 0, 2, 0, 0, 1));
        for (int i = 1; i <= 8; i++) begin
            pulse_a();
            chk("R5 ext prescale /4", pos, W'(i / 4));
        end

        // R5 timer sweep over all divider codes
        for (int c = 0; c < 8; c++) begin
            int dv;
            dv = (c == 7) ? 256 : (1 << c);
            wr(3'd0, mk(0, 0, 0, c, 0, 0, 3));
            wr(3'd1, '0);
            wr(3'd0, mk(1, 0, 0, c, 0, 0, 3));
            repeat (600) @(negedge clk);
            chk("R5 timer count", pos, W'(600 / dv));
        end

        // R12 timer modes ignore policy and index
        for (int s = 2; s < 4; s++) begin
            wr(3'd0, mk(0, 1, 0, 0, 0, 1, s));
            wr(3'd1, 32'd77);
            gate_in = 0; settle();
            wr(3'd0, mk(1, 1, 0, 0, 0, 1, s));
            pulse_idx();
            chk("R12 index ignored in timer source", pos, 32'd77);
            pulse_home();
            chk("R12 home ignored in timer source", pos, 32'd77);
        end

        // R7 index qualification sweep
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
        wr(3'd1, 32'd500); exp_pos = 32'd500;
        wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0));
        pulse_idx(); chk("R7 policy 000 ignores index", pos, exp_pos);
        for (int m = 0; m < 4; m++) begin
            wr(3'd0, mk(1, 1, m, 0, 0, 0, 0));
            for (int s = 0; s < 4; s++) begin
                qmove(1, 0, 1);
                pulse_idx();
                if (ba == m[1:0]) exp_pos = '0;
                chk("R7 qualified index clear", pos, exp_pos);
            end
        end

        // R8 next-index load
        wr(3'd2, 32'h1234_5678);
        wr(3'd0, mk(1, 2, ba, 0, 0, 0, 0));
        pulse_idx(); exp_pos = 32'h1234_5678;
        chk("R8 first index loads", pos, exp_pos);
        qmove(1, 0, 1); qmove(0, 0, 1); qmove(0, 0, 1);
        pulse_idx(); chk("R8 later index ignored", pos, exp_pos);
        wr(3'd0, mk(1, 2, ba, 0, 0, 0, 0));
        pulse_idx(); exp_pos = 32'h1234_5678;
        chk("R8 rearmed by control write", pos, exp_pos);

        // R9 first index after home
        wr(3'd2, 32'hCAFE_0001);
        qmove(1, 0, 1); qmove(0, 0, 1); qmove(0, 0, 1);
        wr(3'd0, mk(1, 3, ba, 0, 0, 0, 0));
        pulse_idx(); chk("R9 index before home ignored", pos, exp_pos);
        pulse_home();
        pulse_idx(); exp_pos = 32'hCAFE_0001;
        chk("R9 first index after home loads", pos, exp_pos);
        qmove(1, 0, 1); qmove(0, 0, 1); qmove(0, 0, 1);
        pulse_idx(); chk("R9 second index not reloaded", pos, exp_pos);
        // R9 second index after home
        wr(3'd2, 32'hBEEF_0002);
        wr(3'd0, mk(1, 4, ba, 0, 0, 0, 0));
        pulse_home();
        pulse_idx(); chk("R9 first index after home skipped", pos, exp_pos);
        pulse_idx(); exp_pos = 32'hBEEF_0002;
        chk("R9 second index loads", pos, exp_pos);
        qmove(1, 0, 1); qmove(0, 0, 1); qmove(0, 0, 1);
        pulse_idx(); chk("R9 third index ignored", pos, exp_pos);

        // R10 compare clear
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
        wr(3'd1, '0); exp_pos = '0;
        wr(3'd3, 32'd3); m_cv = 32'd3; mdl_cmp = 1;
        wr(3'd0, mk(1, 5, 0, 0, 0, 0, 0));
        for (int i = 0; i < 6; i++) begin
            qmove(1, 0, 1); chk("R10 compare clear", pos, exp_pos);
        end
        mdl_cmp = 0;

        // R11 modulo
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 32'd2); wr(3'd5, 32'd5); wr(3'd1, 32'd4);
        m_lo = 32'd2; m_hi = 32'd5; exp_pos = 32'd4; mdl_mod = 1;
        wr(3'd0, mk(1, 6, 0, 0, 0, 0, 0));
        for (int i = 0; i < 4; i++) begin
            qmove(1, 0, 1); chk("R11 modulo up wrap", pos, exp_pos);
        end
        for (int i = 0; i < 4; i++) begin
            qmove(0, 0, 1); chk("R11 modulo down wrap", pos, exp_pos);
        end
        wr(3'd0, mk(1, 7, ba, 0, 0, 0, 0));
        pulse_idx(); exp_pos = '0;
        chk("R11 modulo index clear", pos, exp_pos);
        mdl_mod = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule